// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC and decides whether an incoming frame is addressed to this station. The six destination-address bytes are fed in one byte at a time, first byte first. While they arrive, the block runs a bit-serial reflected CRC-32 over them and compares each byte against the programmed station address.

After the sixth byte, the six most significant CRC bits form an index into a 64-bit hash table. The host supplies that table as a low and a high 32-bit word. There are two such tables: one for group (multicast) addresses and one for individual addresses. Bit 0 of the first address byte picks which table is used.

One cycle after the last byte, the block presents a single-cycle result. The result carries the hash index, the hash hit, the exact-match hit and an overall accept flag. A promiscuous input forces acceptance. Gaps between bytes are allowed. A fresh start-of-address marker restarts the hash at any time.

Top module: `afl_top`

## Requirements
- R1: After reset, `res_vld`, `accept`, `hash_hit` and `exact_hit` are 0 until a complete address has been taken in.
- R2: The CRC is loaded with all ones on the byte marked by `sof`. Each byte is consumed LSB first over eight steps. At each step, if the data bit XOR the CRC bit 0 is 1, the CRC shifts right and is XORed with 0xEDB88320; otherwise it only shifts right. `hash_idx` is CRC bits 31..26 after the sixth byte, with no final inversion.
- R3: A `hash_idx` of 32 or more selects bit `hash_idx`-32 of the high table word. A smaller index selects bit `hash_idx` of the low table word.
- R4: The group table (`grp_lo`/`grp_hi`) is used when bit 0 of the first address byte is 1. Otherwise the individual table (`ind_lo`/`ind_hi`) is used.
- R5: `exact_hit` is 1 when all six bytes equal the station address. Bytes 0..3 are compared with `sta_lo[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`. Bytes 4 and 5 are compared with `sta_hi[31:24]` and `sta_hi[23:16]`. `sta_hi[15:0]` has no effect.
- R6: `res_vld` is 1 for exactly one cycle, in the cycle after the clock edge that takes the sixth byte. Idle cycles (`byte_vld`=0) between bytes do not change the result.
- R7: `accept` equals `exact_hit` OR `hash_hit` OR the value `promisc` had with the sixth byte.
- R8: A byte with `sof`=1 arriving partway through an address discards the partial address and starts a new one. The result then depends only on the new bytes.
- R9: While no address is in progress, bytes with `sof`=0 are ignored and produce no `res_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof | input | 1 | Marks the first address byte (qualified by byte_vld) |
| byte_vld | input | 1 | Address byte present on byte_in |
| byte_in | input | 8 | Address byte |
| promisc | input | 1 | Accept every frame |
| sta_lo | input | 32 | Station address bytes 0..3, byte 0 in the top bits |
| sta_hi | input | 32 | Station address bytes 4..5 in bits 31..16 |
| ind_lo | input | 32 | Individual hash table, indices 0..31 |
| ind_hi | input | 32 | Individual hash table, indices 32..63 |
| grp_lo | input | 32 | Group hash table, indices 0..31 |
| grp_hi | input | 32 | Group hash table, indices 32..63 |
| res_vld | output | 1 | One-cycle result strobe |
| accept | output | 1 | Frame accepted |
| hash_hit | output | 1 | Indexed hash-table bit was set |
| exact_hit | output | 1 | Address equals station address |
| hash_idx | output | 6 | CRC bits 31..26 |

## Verification
All results come from the clock edge that takes the sixth byte and are due one cycle later. The bench drives inputs on the falling edge. It then samples every result field on the falling edge straight after the edge that took the sixth byte. On the following falling edge it checks that `res_vld` has dropped again. Gapped delivery, aborted addresses and stray bytes are checked the same way. For stray bytes, the bench also watches `res_vld` on every cycle while they are being fed in.

// File: rtl/afl_pkg.sv
package afl_pkg;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned CRC_W      = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_INIT = '1;

  // Eight reflected LFSR steps, data LSB first.
  function automatic logic [CRC_W-1:0] crc_step8(input logic [CRC_W-1:0] c_in,
                                                 input logic [7:0] d);
    logic [CRC_W-1:0] c;
    c = c_in;
    for (int b = 0; b < 8; b++) begin
      if (d[b] ^ c[0]) c = (c >> 1) ^ CRC_POLY;
      else             c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/afl_crc.sv
module afl_crc
  import afl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic [7:0]       din,
  output logic [CRC_W-1:0] crc_nxt
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] base;

  always_comb begin
    base    = load ? CRC_INIT : crc_q;
    crc_nxt = crc_step8(base, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  crc_q <= CRC_INIT;
    else if (en) crc_q <= crc_nxt;
  end
endmodule

// File: rtl/afl_match.sv
module afl_match (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       load,
  input  logic [7:0] din,
  input  logic [7:0] ref_byte,
  output logic       match_nxt
);
  logic match_q;

  always_comb begin
    match_nxt = (load ? 1'b1 : match_q) & (din == ref_byte);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  match_q <= 1'b0;
    else if (en) match_q <= match_nxt;
  end
endmodule

// File: rtl/afl_lookup.sv
module afl_lookup #(
  parameter int unsigned IDX_W = 6,
  localparam int unsigned HALF_W = (2 ** IDX_W) / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic              use_grp,
  input  logic [HALF_W-1:0] ind_lo,
  input  logic [HALF_W-1:0] ind_hi,
  input  logic [HALF_W-1:0] grp_lo,
  input  logic [HALF_W-1:0] grp_hi,
  output logic              hit
);
  logic [HALF_W-1:0] word;

  always_comb begin
    if (idx[IDX_W-1]) word = use_grp ? grp_hi : ind_hi;
    else              word = use_grp ? grp_lo : ind_lo;
    hit = word[idx[IDX_W-2:0]];
  end

  // R3/R4: an all-zero selected table can never hit
  a_r4_empty_table: assert property (@(posedge clk) disable iff (!rst_n)
    (use_grp && grp_lo == '0 && grp_hi == '0) |-> !hit);
  a_r3_empty_ind: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_grp && ind_lo == '0 && ind_hi == '0) |-> !hit);
endmodule

// File: rtl/afl_top.sv
module afl_top
  import afl_pkg::*;
#(
  parameter int unsigned IDX_W = 6,
  localparam int unsigned HALF_W = (2 ** IDX_W) / 2,
  localparam int unsigned CNT_W  = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  logic              byte_vld,
  input  logic [7:0]        byte_in,
  input  logic              promisc,
  input  logic [31:0]       sta_lo,
  input  logic [31:0]       sta_hi,
  input  logic [HALF_W-1:0] ind_lo,
  input  logic [HALF_W-1:0] ind_hi,
  input  logic [HALF_W-1:0] grp_lo,
  input  logic [HALF_W-1:0] grp_hi,
  output logic              res_vld,
  output logic              accept,
  output logic              hash_hit,
  output logic              exact_hit,
  output logic [IDX_W-1:0]  hash_idx
);
  logic [CNT_W-1:0] cnt_q, cnt_d, pos;
  logic             take, last;
  logic             grp_q, grp_use;
  logic [47:0]      sta_all;
  logic [7:0]       ref_byte;
  logic [CRC_W-1:0] crc_nxt;
  logic             match_nxt, hit_nxt;

  // Sequencing: position of the current byte inside the address
  always_comb begin
    take     = byte_vld && (sof || cnt_q != '0);
    pos      = sof ? '0 : cnt_q;
    last     = take && (pos == CNT_W'(ADDR_BYTES - 1));
    cnt_d    = !take ? cnt_q : (last ? '0 : pos + 1'b1);
    grp_use  = sof ? byte_in[0] : grp_q;
    sta_all  = {sta_lo, sta_hi[31:16]};
    ref_byte = sta_all[47 - 8*pos -: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      grp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (take && sof) grp_q <= byte_in[0];
    end
  end

  afl_crc u_crc (
    .clk(clk), .rst_n(rst_n), .en(take), .load(sof),
    .din(byte_in), .crc_nxt(crc_nxt)
  );

  afl_match u_match (
    .clk(clk), .rst_n(rst_n), .en(take), .load(sof),
    .din(byte_in), .ref_byte(ref_byte), .match_nxt(match_nxt)
  );

  afl_lookup #(.IDX_W(IDX_W)) u_lookup (
    .clk(clk), .rst_n(rst_n),
    .idx(crc_nxt[CRC_W-1 -: IDX_W]), .use_grp(grp_use),
    .ind_lo(ind_lo), .ind_hi(ind_hi), .grp_lo(grp_lo), .grp_hi(grp_hi),
    .hit(hit_nxt)
  );

  // Result registers, loaded on the last byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld   <= 1'b0;
      accept    <= 1'b0;
      hash_hit  <= 1'b0;
      exact_hit <= 1'b0;
      hash_idx  <= '0;
    end else begin
      res_vld <= last;
      if (last) begin
        accept    <= match_nxt | hit_nxt | promisc;
        hash_hit  <= hit_nxt;
        exact_hit <= match_nxt;
        hash_idx  <= crc_nxt[CRC_W-1 -: IDX_W];
      end
    end
  end

  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |=> !res_vld);
  a_r6_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> $past(byte_vld));
  a_r7_accept_or: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> (accept == (exact_hit | hash_hit | $past(promisc))));
  a_r9_idle_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && byte_vld && !sof) |=> (cnt_q == '0 && !res_vld));
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && sof) |=> (cnt_q == CNT_W'(1)));
endmodule

// File: tb/tb_afl_top.sv
module tb_afl_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sof, byte_vld, promisc;
  logic [7:0]  byte_in;
  logic [31:0] sta_lo, sta_hi, ind_lo, ind_hi, grp_lo, grp_hi;
  logic        res_vld, accept, hash_hit, exact_hit;
  logic [5:0]  hash_idx;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  afl_top dut (
    .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld), .byte_in(byte_in),
    .promisc(promisc), .sta_lo(sta_lo), .sta_hi(sta_hi),
    .ind_lo(ind_lo), .ind_hi(ind_hi), .grp_lo(grp_lo), .grp_hi(grp_hi),
    .res_vld(res_vld), .accept(accept), .hash_hit(hash_hit),
    .exact_hit(exact_hit), .hash_idx(hash_idx)
  );

  function automatic logic [5:0] m_idx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] d = a[47-8*k -: 8];
      for (int b = 0; b < 8; b++) begin
        if (d[b] ^ c[0]) c = (c >> 1) ^ 32'hEDB88320;
        else             c = c >> 1;
      end
    end
    return c[31:26];
  endfunction

  function automatic logic m_hit(input logic [47:0] a);
    logic [5:0] i = m_idx(a);
    logic [31:0] w;
    if (a[40]) w = i[5] ? grp_hi : grp_lo;
    else       w = i[5] ? ind_hi : ind_lo;
    return w[i[4:0]];
  endfunction

  function automatic logic m_exact(input logic [47:0] a);
    return a == {sta_lo, sta_hi[31:16]};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] a, input int gap, input int nbytes);
    for (int k = 0; k < nbytes; k++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); byte_vld = 1'b0; sof = 1'b0;
      end
      @(negedge clk);
      byte_vld = 1'b1; sof = (k == 0); byte_in = a[47-8*k -: 8];
    end
    @(negedge clk); byte_vld = 1'b0; sof = 1'b0;
  endtask

  task automatic check_result(input string req, input logic [47:0] a, input logic pr);
    logic h = m_hit(a);
    logic e = m_exact(a);
    chk(req, "res_vld", 32'(res_vld), 1);
    chk("R2", "hash_idx", 32'(hash_idx), 32'(m_idx(a)));
    chk("R3", "hash_hit", 32'(hash_hit), 32'(h));
    chk("R5", "exact_hit", 32'(exact_hit), 32'(e));
    chk("R7", "accept", 32'(accept), 32'(h | e | pr));
    @(negedge clk);
    chk("R6", "res_vld drop", 32'(res_vld), 0);
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [47:0] a;
    logic [5:0]  i;
    void'($urandom(32'd7741));
    rst_n = 1'b0; sof = 0; byte_vld = 0; byte_in = 0; promisc = 0;
    sta_lo = 0; sta_hi = 0; ind_lo = 0; ind_hi = 0; grp_lo = 0; grp_hi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "res_vld", 32'(res_vld), 0);
    chk("R1", "accept", 32'(accept), 0);
    chk("R1", "hash_hit", 32'(hash_hit), 0);
    chk("R1", "exact_hit", 32'(exact_hit), 0);

    // R3/R4 directed: broadcast, only the indexed bit set in the group table
    a = 48'hFFFF_FFFF_FFFF;
    i = m_idx(a);
    if (i[5]) grp_hi = 32'h1 << i[4:0]; else grp_lo = 32'h1 << i[4:0];
    send(a, 0, 6);
    chk("R4", "group hit", 32'(hash_hit), 1);
    check_result("R3", a, 0);
    // same bit only in the individual table: group address must miss (R4)
    ind_hi = grp_hi; ind_lo = grp_lo; grp_hi = 0; grp_lo = 0;
    send(a, 0, 6);
    chk("R4", "individual table unused", 32'(hash_hit), 0);
    check_result("R4", a, 0);
    // right offset in the wrong half must miss (R3)
    grp_lo = ind_hi; grp_hi = ind_lo; ind_lo = 0; ind_hi = 0;
    send(a, 0, 6);
    chk("R3", "wrong half", 32'(hash_hit), 0);
    check_result("R3", a, 0);

    // R9: stray bytes while idle
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); byte_vld = 1'b1; sof = 1'b0; byte_in = 8'(k);
      chk("R9", "no res_vld", 32'(res_vld), 0);
    end
    @(negedge clk); byte_vld = 1'b0;
    chk("R9", "no res_vld end", 32'(res_vld), 0);
    @(negedge clk);
    chk("R9", "no res_vld late", 32'(res_vld), 0);

    // R8: aborted partial address then new one
    sta_lo = $urandom; sta_hi = $urandom;
    a = {sta_lo, sta_hi[31:16]};
    send(48'hA5A5_1234_5678, 0, 3);
    send(a, 0, 6);
    chk("R8", "exact after restart", 32'(exact_hit), 1);
    check_result("R8", a, 0);

    // Random mix
    for (int t = 0; t < 60; t++) begin
      logic pr;
      sta_lo = $urandom; sta_hi = $urandom;
      ind_lo = $urandom; ind_hi = $urandom; grp_lo = $urandom; grp_hi = $urandom;
      if (t % 3 == 0) begin ind_lo = 0; grp_hi = 0; end
      pr = ($urandom % 5) == 0;
      promisc = pr;
      if ($urandom % 3 == 0) a = {sta_lo, sta_hi[31:16]};
      else a = {16'($urandom), 32'($urandom)};
      if (t % 4 == 1) a[40] = ~a[40];
      send(a, t % 3, 6);
      promisc = $urandom;  // value after last byte must not matter (R7)
      check_result("R6", a, pr);
      promisc = 0;
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule